// File: doc/BRIEF.md
# Clocked Serial Port with Slave Select

This block is an 8-bit synchronous serial port with three wires: a serial clock, a data output and a data input. It also has an optional active-low select input. Software controls it through a small register bus with three locations: a mode register, a transmit buffer and the shift register. There is no separate start command. A transfer begins as a side effect of a bus access. In transmit/receive mode, writing the transmit buffer loads the shift register and starts the byte. In receive-only mode, reading the shift register returns the byte received last and starts the next reception.

In master mode the port generates the serial clock from an internal divider. The clock idles high. Data changes on each falling edge and is sampled on each rising edge. In slave mode the serial clock, the data input and the select input pass through a two-flop synchronizer, and edge detection works on the synchronized clock.

When select gating is enabled in slave mode, the select input controls transfers:
- A trigger that arrives while select is high is held pending. It starts once select goes low.
- A high select level during a transfer pauses the transfer. While paused, serial clock edges are ignored, and the transfer continues when select returns low.

Top module: `csio_port`

## Requirements
- R1: After reset `busy` and `done_pulse` are 0, `sck_o` and `sdo` are 1, and the mode register reads 0x00.
- R2: Address 0 is the mode register. Bit 6 selects transmit/receive (1) or receive-only (0). Bit 5 enables select gating. Bit 4 selects slave (1) or master (0). Bit 3 selects LSB-first (1) or MSB-first (0). Bits 6..3 read back as written, and bit 0 reads the busy state. Address 1 is the transmit buffer (write). Address 2 is the shift register (read). Read data appears on `bus_rdata` one cycle after `bus_re`.
- R3: In transmit/receive mode, a write to address 1 starts a transfer. The port shifts out the 8 written bits on `sdo`, changing on each serial clock fall. It captures 8 bits from `sdi` on each rise, and the captured byte is readable at address 2.
- R4: In receive-only mode, a read of address 2 starts a reception. `sdo` stays 1 for the whole reception, and a write to address 1 starts nothing.
- R5: `busy` rises in the cycle after the start and falls after the eighth sampling edge. `done_pulse` is high for exactly the one cycle in which `busy` has just fallen.
- R6: With bit 3 set, data is sent and assembled LSB first. The written byte and the peer's byte are still delivered intact.
- R7: In master mode `sck_o` idles high. During a transfer it produces 8 low phases, each lasting exactly HALF_CYC clock cycles.
- R8: While `busy` is 1, writes to the mode register and to the transmit buffer are ignored.
- R9: In slave mode `sck_o` stays 1. The shift timing follows the edges of `sck_i`.
- R10: In slave mode with select gating, a trigger made while `ssel_n` is high does not raise `busy`. The transfer starts once `ssel_n` goes low.
- R11: In slave mode with select gating, a high `ssel_n` during a transfer pauses it. `sck_i` edges are ignored while paused, and the transfer resumes when `ssel_n` is low again.
- R12: In slave mode without select gating, `ssel_n` has no effect. A trigger starts the transfer at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| ssel_n | input | 1 | Active-low select input |
| busy | output | 1 | Transfer in progress |
| done_pulse | output | 1 | One-cycle completion interrupt request |

## Verification
The assertions assume the bus never issues a write and a read in the same cycle. They also assume that software only changes the mode while the port is idle, which is why mode stability is checked only while busy. In slave mode they assume that `sck_i` and `sdi` hold each level for many clock cycles, and that `ssel_n` settles well before the next `sck_i` edge. The bench keeps to these limits by using a serial half period of 10 clocks in slave mode. It also waits several cycles after every `ssel_n` change before it moves `sck_i`.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_TXBUF = 2'd1;
  localparam logic [1:0] ADDR_SHIFT = 2'd2;

  localparam int MB_TXRX  = 6;
  localparam int MB_SELEN = 5;
  localparam int MB_SLAVE = 4;
  localparam int MB_LSB   = 3;
  localparam int MB_BUSY  = 0;

  typedef struct packed {
    logic txrx;
    logic sel_en;
    logic slave;
    logic lsb_first;
  } mode_t;
endpackage

// File: rtl/csio_sync.sv
module csio_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        stage[i] <= RST_VAL;
      else if (i == 0)
        stage[i] <= d;
      else
        stage[i] <= stage[(i > 0) ? i - 1 : 0];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/csio_clkgen.sv
module csio_clkgen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == CNT_LAST);
  assign fall_stb = wrap && sck;
  assign rise_stb = wrap && !sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              start,
  input  logic              fall_stb,
  input  logic              rise_stb,
  input  logic              sdi,
  input  logic              lsb_first,
  input  logic              tx_en,
  output logic [DATA_W-1:0] shreg,
  output logic              sdo,
  output logic              last
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt;
  logic             out_bit;

  assign out_bit = lsb_first ? shreg[0] : shreg[DATA_W-1];
  assign last    = rise_stb && (cnt == CNT_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
      sdo   <= 1'b1;
    end else begin
      if (load)
        shreg <= load_data;
      else if (rise_stb)
        shreg <= lsb_first ? {sdi, shreg[DATA_W-1:1]} : {shreg[DATA_W-2:0], sdi};

      if (start)
        cnt <= '0;
      else if (rise_stb)
        cnt <= cnt + 1'b1;

      if (start)
        sdo <= 1'b1;
      else if (fall_stb && tx_en)
        sdo <= out_bit;
    end
  end
endmodule

// File: rtl/csio_port.sv
module csio_port
  import csio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              sdi,
  output logic              sdo,
  input  logic              ssel_n,
  output logic              busy,
  output logic              done_pulse
);
  mode_t             mode_q;
  logic              busy_q, pend_q;
  logic [2:0]        pin_sync;
  logic              sck_s, sdi_s, ss_s, sck_prev;
  logic              m_fall, m_rise, s_fall, s_rise;
  logic              fall_g, rise_g, last;
  logic              ss_high, locked;
  logic              trig_tx, trig_rx, trig, start;
  logic [DATA_W-1:0] shreg;
  logic [7:0]        mode_byte;

  csio_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst(rst), .d({ssel_n, sdi, sck_i}), .q(pin_sync)
  );
  assign {ss_s, sdi_s, sck_s} = pin_sync;

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b1;
    else     sck_prev <= sck_s;
  end
  assign s_fall = sck_prev && !sck_s;
  assign s_rise = !sck_prev && sck_s;

  csio_clkgen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk(clk), .rst(rst), .run(busy_q && !mode_q.slave),
    .sck(sck_o), .fall_stb(m_fall), .rise_stb(m_rise)
  );

  assign ss_high = mode_q.slave && mode_q.sel_en && ss_s;
  assign locked  = busy_q || pend_q;
  assign trig_tx = bus_we && (bus_addr == ADDR_TXBUF) && mode_q.txrx && !locked;
  assign trig_rx = bus_re && (bus_addr == ADDR_SHIFT) && !mode_q.txrx && !locked;
  assign trig    = trig_tx || trig_rx;
  assign start   = (trig || pend_q) && !ss_high;

  assign fall_g = busy_q && !ss_high && (mode_q.slave ? s_fall : m_fall);
  assign rise_g = busy_q && !ss_high && (mode_q.slave ? s_rise : m_rise);

  csio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(trig_tx), .load_data(bus_wdata),
    .start(start), .fall_stb(fall_g), .rise_stb(rise_g), .sdi(sdi_s),
    .lsb_first(mode_q.lsb_first), .tx_en(mode_q.txrx),
    .shreg(shreg), .sdo(sdo), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      busy_q     <= 1'b0;
      pend_q     <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      if (bus_we && (bus_addr == ADDR_MODE) && !locked) begin
        mode_q.txrx      <= bus_wdata[MB_TXRX];
        mode_q.sel_en    <= bus_wdata[MB_SELEN];
        mode_q.slave     <= bus_wdata[MB_SLAVE];
        mode_q.lsb_first <= bus_wdata[MB_LSB];
      end
      if (trig && ss_high) pend_q <= 1'b1;
      else if (start)      pend_q <= 1'b0;
      if (last)            busy_q <= 1'b0;
      else if (start)      busy_q <= 1'b1;
      done_pulse <= last;
    end
  end

  always_comb begin
    mode_byte          = '0;
    mode_byte[MB_TXRX]  = mode_q.txrx;
    mode_byte[MB_SELEN] = mode_q.sel_en;
    mode_byte[MB_SLAVE] = mode_q.slave;
    mode_byte[MB_LSB]   = mode_q.lsb_first;
    mode_byte[MB_BUSY]  = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        ADDR_MODE:  bus_rdata <= DATA_W'(mode_byte);
        ADDR_SHIFT: bus_rdata <= shreg;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/csio_port_chk.sv
module csio_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done_pulse,
  input logic       sck_o,
  input logic       sdo,
  input logic [3:0] mode_v
);
  // R5: completion flag marks the cycle right after busy fell
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (!busy && $past(busy)));
  // R5: the flag lasts one cycle
  a_r5_single_done: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);
  // R7: master clock idle level
  a_r7_sck_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck_o);
  // R9: no clock driven in slave mode
  a_r9_slave_quiet: assert property (@(posedge clk) disable iff (rst)
    mode_v[1] |-> sck_o);
  // R8: mode frozen during a transfer
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_v));
  // R4: data output held high while receiving only
  a_r4_rx_only_sdo: assert property (@(posedge clk) disable iff (rst)
    (busy && !mode_v[3]) |-> sdo);
endmodule

bind csio_port csio_port_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done_pulse(done_pulse),
  .sck_o(sck_o), .sdo(sdo), .mode_v(mode_q)
);

// File: tb/csio_port_test.sv
module csio_port_test;
  localparam int HALF = 4;
  localparam int SHALF = 10;

  logic clk = 0, rst = 1;
  logic bus_we = 0, bus_re = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sck_i = 1, sck_o, sdo, ssel_n = 1, busy, done_pulse;
  logic sdi, sdi_m = 1, sdi_s = 1;

  int tests = 0, fails = 0, cyc = 0, done_cnt = 0;
  bit slave_tb = 0, sel_tb = 0, lsb_tb = 0;
  logic [7:0] peer_byte = 0;
  int sidx = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  assign sdi = slave_tb ? sdi_s : sdi_m;

  csio_port #(.DATA_W(8), .HALF_CYC(HALF), .SYNC_STG(2)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_i(sck_i), .sck_o(sck_o),
    .sdi(sdi), .sdo(sdo), .ssel_n(ssel_n), .busy(busy), .done_pulse(done_pulse)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic peer_bit(input int i);
    return lsb_tb ? peer_byte[i] : peer_byte[7-i];
  endfunction

  // monitor / scoreboard
  logic line_prev = 1;
  logic [7:0] cap = 0;
  int bits = 0, lowrun = 0, pidx = 0;
  always @(negedge clk) begin
    logic line;
    line = slave_tb ? sck_i : sck_o;
    if (!rst) begin
      if (line && !line_prev && !(sel_tb && ssel_n)) begin
        cap = lsb_tb ? {sdo, cap[7:1]} : {cap[6:0], sdo};
        bits++;
        if (!slave_tb) chk(lowrun == HALF, "R7 low phase", lowrun, HALF);
      end
      if (!line && line_prev && !slave_tb) begin
        sdi_m = peer_bit(pidx);
        pidx++;
      end
      lowrun = line ? 0 : lowrun + 1;
      if (done_pulse) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected completion", 1, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cap == e, t, cap, e);
          chk(bits == 8, "R7/R9 edge count", bits, 8);
        end
        cap = 0; bits = 0; pidx = 0;
        done_cnt++;
      end
    end
    line_prev = line;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    bus_re = 1; bus_addr = a;
    @(posedge clk); #1;
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic wait_done();
    int n0 = done_cnt;
    int g = 0;
    while (done_cnt == n0 && g < 5000) begin
      @(posedge clk); g++;
    end
    @(posedge clk); #1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic slave_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sck_i = 0; sdi_s = peer_bit(sidx); sidx++;
      wait_cyc(SHALF);
      sck_i = 1;
      wait_cyc(SHALF);
    end
  endtask

  task automatic dummy_toggles(input int n);
    for (int i = 0; i < n; i++) begin
      sck_i = 0; wait_cyc(SHALF);
      sck_i = 1; wait_cyc(SHALF);
    end
  endtask

  initial begin
    logic [7:0] rd;
    int n0;
    wait_cyc(4);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(sck_o == 1 && sdo == 1, "R1 pins", {sck_o, sdo}, 3);
    bus_read(2'd0, rd);
    chk(rd == 8'h00, "R1 mode reset", rd, 0);

    // R2 mode readback
    bus_write(2'd0, 8'h40);
    bus_read(2'd0, rd);
    chk(rd == 8'h40, "R2 mode readback", rd, 8'h40);

    // R3 master MSB-first transmit/receive, R5, R8
    lsb_tb = 0; peer_byte = 8'h3C;
    exp_q.push_back(8'hA5); tag_q.push_back("R3 sdo byte");
    bus_write(2'd1, 8'hA5);
    chk(busy == 1, "R5 busy after start", busy, 1);
    bus_read(2'd0, rd);
    chk(rd[0] == 1, "R2 busy bit", rd, 1);
    bus_write(2'd0, 8'h08);   // R8 ignored
    bus_write(2'd1, 8'hFF);   // R8 ignored
    wait_done();
    chk(busy == 0 && sck_o == 1, "R7 idle after transfer", {busy, sck_o}, 1);
    bus_read(2'd2, rd);
    chk(rd == 8'h3C, "R3 received byte", rd, 8'h3C);
    bus_read(2'd0, rd);
    chk(rd == 8'h40, "R8 mode write ignored", rd, 8'h40);

    // R6 LSB first
    bus_write(2'd0, 8'h48);
    lsb_tb = 1; peer_byte = 8'hC3;
    exp_q.push_back(8'h1E); tag_q.push_back("R6 sdo byte");
    bus_write(2'd1, 8'h1E);
    wait_done();
    bus_read(2'd2, rd);
    chk(rd == 8'hC3, "R6 received byte", rd, 8'hC3);

    // R4 receive-only
    bus_write(2'd0, 8'h00);
    lsb_tb = 0; peer_byte = 8'h96;
    exp_q.push_back(8'hFF); tag_q.push_back("R4 sdo idle");
    bus_read(2'd2, rd);
    chk(busy == 1, "R4 read starts reception", busy, 1);
    wait_done();
    exp_q.push_back(8'hFF); tag_q.push_back("R4 sdo idle 2");
    bus_read(2'd2, rd);
    chk(rd == 8'h96, "R4 received byte", rd, 8'h96);
    peer_byte = 8'h00;
    wait_done();
    n0 = done_cnt;
    bus_write(2'd1, 8'h77);
    wait_cyc(20);
    chk(busy == 0 && done_cnt == n0, "R4 write starts nothing", busy, 0);

    // R9 / R12 slave, gating off, select high
    bus_write(2'd0, 8'h50);
    slave_tb = 1; sel_tb = 0; ssel_n = 1; peer_byte = 8'h81; sidx = 0;
    exp_q.push_back(8'h5A); tag_q.push_back("R9 slave sdo byte");
    bus_write(2'd1, 8'h5A);
    chk(busy == 1, "R12 select ignored", busy, 1);
    slave_bits(8);
    wait_done();
    chk(sck_o == 1, "R9 sck_o quiet", sck_o, 1);
    bus_read(2'd2, rd);
    chk(rd == 8'h81, "R9 slave received byte", rd, 8'h81);

    // R10 / R11 slave with gating
    bus_write(2'd0, 8'h70);
    sel_tb = 1; peer_byte = 8'h2B; sidx = 0;
    exp_q.push_back(8'hC6); tag_q.push_back("R11 sdo byte");
    bus_write(2'd1, 8'hC6);
    wait_cyc(20);
    chk(busy == 0, "R10 held while select high", busy, 0);
    ssel_n = 0;
    wait_cyc(6);
    chk(busy == 1, "R10 starts on select low", busy, 1);
    slave_bits(4);
    ssel_n = 1;
    wait_cyc(6);
    n0 = done_cnt;
    dummy_toggles(2);
    chk(busy == 1 && done_cnt == n0, "R11 paused", busy, 1);
    ssel_n = 0;
    wait_cyc(6);
    slave_bits(4);
    wait_done();
    bus_read(2'd2, rd);
    chk(rd == 8'h2B, "R11 received byte", rd, 8'h2B);
    chk(exp_q.size() == 0, "R5 all transfers completed", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule